// File: doc/BRIEF.md
# CPU Presence Bitmap Port

This block keeps a presence bitmap with one bit per CPU and exposes it to firmware as a read-only, byte-wide window of 32 bytes on a simple I/O bus. Bit `j` of byte `k` stands for CPU identifier `8*k + j`. A set bit means that CPU is present. The boot CPU, identifier 0, is always reported as present.

A hot-add input carries a CPU identifier. It sets that CPU's bit and raises a general-purpose event status bit, which drives an SCI line toward firmware. The SCI stays high until firmware acknowledges it. Hardware never clears a presence bit.

Writes to the window never change the bitmap. They feed a one-way mode latch instead. When zero has been written to each of the four bytes of the first dword, the block switches from the legacy interface to the modern one. It then signals the modern register block through `modern_o`. Only reset brings the latch back to legacy.

Top module: `cpu_present_map`

## Requirements
- R1: After reset, only bit 0 of the bitmap is set, `modern_o` is 0, `sci_o` is 0, `evt_sts_o` is 0 and `rdata_o` is 0.
- R2: A cycle with `rd_i` high and offset `k` on `addr_i` puts bitmap byte `k` on `rdata_o` after the next clock edge. Bit `j` of that byte is the presence of CPU `8*k+j`. `rdata_o` holds its value until the next read.
- R3: In legacy mode, bit 0 of byte 0 always reads as 1.
- R4: A hot-add (`hotadd_i` high) with `hotadd_id_i` below `NUM_CPUS` sets that CPU's bit at the clock edge. Only reset clears a presence bit.
- R5: A valid hot-add sets bit 2 of `evt_sts_o`, and `sci_o` is high whenever any bit of `evt_sts_o` is set. The status stays set until a cycle with `sci_ack_i` high clears it. If a hot-add and an acknowledge arrive in the same cycle, the hot-add wins.
- R6: A hot-add with an identifier of `NUM_CPUS` or more changes no bit and raises no event.
- R7: Bitmap bits for identifiers of `NUM_CPUS` or more always read as 0.
- R8: Writes to any offset never change the bitmap contents.
- R9: `modern_o` rises after the clock edge of the write that completes the switch. The switch is complete once zero has been written to all of offsets 0 to 3, in any order, with no nonzero write to offsets 0 to 3 in between. A nonzero write to offsets 0 to 3 discards that progress. Writes to offsets 4 and above do not affect it.
- R10: Once `modern_o` is 1, it stays 1 until reset. In modern mode, window reads return 0 and window writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Byte read strobe |
| wr_i | input | 1 | Byte write strobe |
| addr_i | input | 5 | Byte offset within the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| hotadd_i | input | 1 | Hot-add event strobe |
| hotadd_id_i | input | 8 | Identifier of the added CPU |
| evt_sts_o | output | 4 | Event status; bit 2 marks a CPU hot-add |
| sci_o | output | 1 | Interrupt toward firmware |
| sci_ack_i | input | 1 | Acknowledge, clears the event status |
| modern_o | output | 1 | 1 once the modern interface is selected |

## Verification
The bench goes after these corner cases:
- **Partial zero sequences.** Nonzero writes in the middle of a zero sequence, and zero writes just outside the first dword. A design that switches on a single zero byte, or that keeps its progress across a nonzero write, raises `modern_o` too early.
- **Acknowledge against hot-add.** An acknowledge in the same cycle as a new hot-add. A design that lets the acknowledge win drops an event.
- **Out-of-range identifiers.** Hot-adds with identifiers at and above the CPU count. A wrong design sets phantom bits or raises a spurious SCI.
- **Writes to the bitmap.** Writes of ones and of zeros to the bitmap, including a zero to byte 0. These expose a bitmap that is writable or that loses its boot CPU bit.

// File: rtl/cpumap_pkg.sv
package cpumap_pkg;
  typedef enum logic {MODE_LEGACY = 1'b0, MODE_MODERN = 1'b1} iface_mode_e;
  // bytes of the first dword that must all see a zero write
  localparam int unsigned SW_BYTES = 4;
endpackage

// File: rtl/cpumap_store.sv
module cpumap_store #(
  parameter int unsigned NUM_CPUS = 256,
  parameter int unsigned MAP_BITS = 256,
  parameter int unsigned ID_W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                add_i,
  input  logic [ID_W-1:0]     add_id_i,
  output logic [MAP_BITS-1:0] map_o,
  output logic                add_ok_o
);
  localparam logic [ID_W:0] CPU_LIM = (ID_W+1)'(NUM_CPUS);

  assign add_ok_o = add_i && ({1'b0, add_id_i} < CPU_LIM);

  for (genvar i = 0; i < MAP_BITS; i++) begin : g_bit
    if (i == 0) begin : g_boot
      assign map_o[i] = 1'b1;  // boot CPU always present
    end else if (i < NUM_CPUS) begin : g_live
      localparam logic [ID_W-1:0] MY_ID = ID_W'(i);
      logic pres_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            pres_q <= 1'b0;
        else if (add_ok_o && add_id_i == MY_ID) pres_q <= 1'b1;
      end
      assign map_o[i] = pres_q;
    end else begin : g_void
      assign map_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cpumap_rdport.sv
module cpumap_rdport #(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MAP_BITS  = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                blank_i,
  input  logic [MAP_BITS-1:0] map_i,
  output logic [7:0]          rdata_o
);
  localparam int unsigned SEL_W = ADDR_W + 3;

  logic [SEL_W-1:0] bit_sel;
  logic [7:0]       byte_w;
  logic [7:0]       rdata_q;

  assign bit_sel = {addr_i, 3'b000};
  assign byte_w  = map_i[bit_sel +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= blank_i ? 8'h00 : byte_w;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cpumap_mode.sv
module cpumap_mode
  import cpumap_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output iface_mode_e       mode_o
);
  localparam int unsigned IDX_W = $clog2(SW_BYTES);

  logic [SW_BYTES-1:0] zmask_q, zmask_nx;
  iface_mode_e         mode_q;
  logic                hit;

  assign hit = wr_i && (mode_q == MODE_LEGACY) && (addr_i < ADDR_W'(SW_BYTES));

  always_comb begin
    zmask_nx = zmask_q;
    if (hit) begin
      if (wdata_i == 8'h00) zmask_nx[addr_i[IDX_W-1:0]] = 1'b1;
      else                  zmask_nx = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zmask_q <= '0;
      mode_q  <= MODE_LEGACY;
    end else begin
      zmask_q <= zmask_nx;
      if (&zmask_nx) mode_q <= MODE_MODERN;  // one-way
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cpumap_evt.sv
module cpumap_evt #(
  parameter int unsigned EVT_W   = 4,
  parameter int unsigned EVT_BIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             ack_i,
  output logic [EVT_W-1:0] sts_o
);
  localparam logic [EVT_W-1:0] EVT_MASK = EVT_W'(1) << EVT_BIT;

  logic [EVT_W-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_q <= '0;
    else if (set_i) sts_q <= sts_q | EVT_MASK;  // set beats ack
    else if (ack_i) sts_q <= '0;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/cpu_present_map.sv
module cpu_present_map
  import cpumap_pkg::*;
#(
  parameter int unsigned NUM_CPUS  = 256,
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned ID_W      = 8,
  parameter int unsigned EVT_W     = 4,
  parameter int unsigned EVT_BIT   = 2,
  localparam int unsigned ADDR_W   = $clog2(WIN_BYTES),
  localparam int unsigned MAP_BITS = WIN_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              hotadd_i,
  input  logic [ID_W-1:0]   hotadd_id_i,
  output logic [EVT_W-1:0]  evt_sts_o,
  output logic              sci_o,
  input  logic              sci_ack_i,
  output logic              modern_o
);
  logic [MAP_BITS-1:0] map_w;
  logic                add_ok;
  iface_mode_e         mode_w;

  cpumap_store #(.NUM_CPUS(NUM_CPUS), .MAP_BITS(MAP_BITS), .ID_W(ID_W)) u_store (
    .clk_i, .rst_ni, .add_i(hotadd_i), .add_id_i(hotadd_id_i),
    .map_o(map_w), .add_ok_o(add_ok)
  );

  cpumap_mode #(.ADDR_W(ADDR_W)) u_mode (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .mode_o(mode_w)
  );

  cpumap_rdport #(.WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W), .MAP_BITS(MAP_BITS)) u_rd (
    .clk_i, .rst_ni, .rd_i, .addr_i, .blank_i(mode_w == MODE_MODERN),
    .map_i(map_w), .rdata_o
  );

  cpumap_evt #(.EVT_W(EVT_W), .EVT_BIT(EVT_BIT)) u_evt (
    .clk_i, .rst_ni, .set_i(add_ok), .ack_i(sci_ack_i), .sts_o(evt_sts_o)
  );

  assign sci_o    = |evt_sts_o;
  assign modern_o = (mode_w == MODE_MODERN);
endmodule

// File: rtl/cpu_present_map_chk.sv
module cpu_present_map_chk #(
  parameter int unsigned NUM_CPUS = 256,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned MAP_BITS = 256
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [7:0]          rdata_o,
  input logic                hotadd_i,
  input logic [ID_W-1:0]     hotadd_id_i,
  input logic                sci_o,
  input logic                sci_ack_i,
  input logic                modern_o,
  input logic [MAP_BITS-1:0] map_i
);
  localparam logic [ID_W:0] CPU_LIM = (ID_W+1)'(NUM_CPUS);
  logic add_ok;
  assign add_ok = hotadd_i && ({1'b0, hotadd_id_i} < CPU_LIM);

  // R3
  boot_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !modern_o && addr_i == '0) |=> rdata_o[0]);
  // R4
  no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_i & $past(map_i)) == $past(map_i));
  // R5
  sci_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_ok |=> sci_o);
  // R5
  sci_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sci_o && !sci_ack_i) |=> sci_o);
  // R5
  sci_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sci_ack_i && !add_ok) |=> !sci_o);
  // R6
  bad_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sci_o && !add_ok) |=> !sci_o);
  // R10
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modern_o |=> modern_o);
  // R10
  blank_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && modern_o) |=> rdata_o == 8'h00);
endmodule

bind cpu_present_map cpu_present_map_chk #(
  .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W), .ID_W(ID_W), .MAP_BITS(MAP_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .hotadd_i(hotadd_i), .hotadd_id_i(hotadd_id_i), .sci_o(sci_o),
  .sci_ack_i(sci_ack_i), .modern_o(modern_o), .map_i(map_w)
);

// File: tb/cpu_present_map_tb.sv
`timescale 1ns/1ps
module cpu_present_map_tb;
  localparam int unsigned NCPU = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd = 1'b0, wr = 1'b0, hadd = 1'b0, ack = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, hid = '0;
  logic [7:0] rdata;
  logic [3:0] evt;
  logic       sci, modern;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_present_map #(.NUM_CPUS(NCPU)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hotadd_i(hadd), .hotadd_id_i(hid),
    .evt_sts_o(evt), .sci_o(sci), .sci_ack_i(ack), .modern_o(modern)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd_byte(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wr_byte(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic add_cpu(input logic [7:0] id, input logic with_ack);
    @(negedge clk); hadd = 1'b1; hid = id; ack = with_ack;
    @(negedge clk); hadd = 1'b0; ack = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check("R1 rdata", rdata, 8'h00);
    check("R1 sci", sci, 1'b0);
    check("R1 evt", evt, 4'h0);
    check("R1 modern", modern, 1'b0);
    rd_byte(5'd0, d); check("R1/R3 byte0", d, 8'h01);
    rd_byte(5'd1, d); check("R1 byte1", d, 8'h00);
  endtask

  task automatic t_hotadd();
    logic [7:0] d;
    add_cpu(8'd5, 1'b0);
    check("R5 sci", sci, 1'b1);
    check("R5 evt bit2", evt, 4'h4);
    rd_byte(5'd0, d); check("R2/R4 byte0", d, 8'h21);
    add_cpu(8'd17, 1'b0);
    rd_byte(5'd2, d); check("R2/R4 byte2", d, 8'h02);
    check("R2 hold", rdata, 8'h02);
    do_ack();
    check("R5 ack clears", sci, 1'b0);
    add_cpu(8'd9, 1'b1);
    check("R5 set wins", sci, 1'b1);
    rd_byte(5'd1, d); check("R4 byte1", d, 8'h02);
    do_ack();
    check("R5 ack evt", evt, 4'h0);
  endtask

  task automatic t_range();
    logic [7:0] d;
    add_cpu(8'd20, 1'b0);
    check("R6 no sci id20", sci, 1'b0);
    add_cpu(8'd200, 1'b0);
    check("R6 no sci id200", sci, 1'b0);
    rd_byte(5'd2, d); check("R6/R7 byte2", d, 8'h02);
    rd_byte(5'd25, d); check("R7 byte25", d, 8'h00);
    rd_byte(5'd31, d); check("R7 byte31", d, 8'h00);
  endtask

  task automatic t_writes();
    logic [7:0] d;
    wr_byte(5'd0, 8'hFF);
    wr_byte(5'd2, 8'hFD);
    wr_byte(5'd10, 8'hFF);
    rd_byte(5'd0, d); check("R8 byte0", d, 8'h21);
    rd_byte(5'd2, d); check("R8 byte2", d, 8'h02);
    rd_byte(5'd10, d); check("R8/R7 byte10", d, 8'h00);
    wr_byte(5'd0, 8'h00);
    rd_byte(5'd0, d); check("R3/R8 zero write", d, 8'h21);
    check("R9 single zero", modern, 1'b0);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    // byte 0 already zero-written
    wr_byte(5'd1, 8'h00);
    wr_byte(5'd2, 8'h00);
    wr_byte(5'd3, 8'h05);
    wr_byte(5'd3, 8'h00);
    check("R9 nonzero restarts", modern, 1'b0);
    wr_byte(5'd4, 8'h00);
    wr_byte(5'd8, 8'h00);
    wr_byte(5'd2, 8'h00);
    wr_byte(5'd0, 8'h00);
    check("R9 three of four", modern, 1'b0);
    wr_byte(5'd1, 8'h00);
    check("R9 switch", modern, 1'b1);
    rd_byte(5'd0, d); check("R10 blank read", d, 8'h00);
    wr_byte(5'd0, 8'hFF);
    wr_byte(5'd1, 8'h12);
    check("R10 sticky", modern, 1'b1);
    add_cpu(8'd3, 1'b0);
    check("R5 sci in modern", sci, 1'b1);
    do_ack();
    do_reset();
    check("R1 modern after reset", modern, 1'b0);
    rd_byte(5'd0, d); check("R1/R4 map reset", d, 8'h01);
    rd_byte(5'd2, d); check("R1 byte2 reset", d, 8'h00);
  endtask

  initial begin
    t_reset();
    t_hotadd();
    t_range();
    t_writes();
    t_mode();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule